// File: doc/BRIEF.md
# Half-Bridge Deadtime Interlock Controller

This block sits between a PWM generator and the gate drivers of one half-bridge leg. It takes a high-side command and a low-side command and produces two gate-enable outputs. It guarantees that the two gate enables are never active together. It also enforces a programmable interval with both gates off between one gate turning off and the opposite gate turning on.

The length of that interval is set by a 9-bit code. Code zero gives the shortest interval, and the length grows by one clock cycle per code step up to a ceiling. If the controller already leaves a gap longer than the interval, the gates follow the commands with no added delay.

Three flags gate the outputs:
- A configuration-valid flag: when it is low, the block enters protection.
- A logic-supply fault: it removes both gates.
- A floating-supply fault: it removes only the high gate.

After any such condition, and after reset, a gate comes back only on a fresh rising command that follows a full interval. A registered status code tells the system what the leg is doing.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: `gate_hi` and `gate_lo` are never both 1 in the same cycle.
- R2: The deadtime length in cycles is L = min(MIN_DT + dt_code, MAX_DT), which is 40 + code capped at 500 by default. When one gate turns off while the opposite command is already high, both gates stay 0 for exactly L cycles before the opposite gate turns on. This holds for high-to-low and for low-to-high with the same L.
- R3: If the opposite command rises more than L cycles after the previous gate turned off, that gate turns on one clock after the command rises.
- R4: While `cmd_hi` and `cmd_lo` are both 1, both gates are 0 from the next cycle on.
- R5: While `cfg_ok` is 0, both gates are 0 from the next cycle and `status` reads 5 (protection).
- R6: While `logic_uv` is 1, both gates are 0 from the next cycle and `status` reads 4 (fault), unless `cfg_ok` is 0.
- R7: While `float_uv` is 1, `gate_hi` is 0 from the next cycle, and `gate_lo` keeps following `cmd_lo`. With both gates off, `status` reads 4.
- R8: After reset, a protection condition or a fault clears, a command that stayed high does not turn its gate on. The gate turns on only after its command has been low once a full deadtime has run out, and then goes high again.
- R9: While `rst_n` is 0, both gates are 0 and `status` reads 3. After release, a deadtime of MAX_DT cycles runs before either gate may turn on.
- R10: `status` encodes 0 idle, 1 high gate on, 2 low gate on, 3 deadtime running. It is updated in the same cycle as the gates.
- R11: `dt_code` is taken only in the cycle a deadtime starts. A change while the deadtime runs does not alter that interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_hi | input | 1 | High-side PWM command |
| cmd_lo | input | 1 | Low-side PWM command |
| dt_code | input | 9 | Deadtime setting code |
| cfg_ok | input | 1 | Deadtime configuration valid |
| logic_uv | input | 1 | Logic supply undervoltage fault |
| float_uv | input | 1 | Floating high-side supply undervoltage fault |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| status | output | 3 | Leg state: 0 idle, 1 high on, 2 low on, 3 deadtime, 4 fault, 5 protection |

## Verification
The assertions check the following on every cycle:
- The two gates are never on together.
- Every gate turn-on follows at least MIN_DT cycles with both gates off.
- Both commands high, a protection condition or a logic fault removes both gates one cycle later.
- A floating-supply fault removes the high gate.
- The status code agrees with whichever gate is on.

Only the bench scenarios can show the following:
- The exact interval for a given code, and that it is equal in both directions.
- The absence of added delay on long gaps.
- That a code change during a running interval is ignored.
- The fresh-edge rule after reset and after each fault.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HI    = 3'd1,
    ST_LO    = 3'd2,
    ST_DEAD  = 3'd3,
    ST_FAULT = 3'd4,
    ST_PROT  = 3'd5
  } hb_state_e;
endpackage

// File: rtl/hbdt_len.sv
// Converts the setting code into (deadtime length - 1), clamped to the ceiling.
module hbdt_len #(
  parameter int MIN_DT = 40,
  parameter int MAX_DT = 500,
  parameter int CODE_W = 9,
  parameter int CNT_W  = 9
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  len_m1
);
  localparam int SUM_W = ((CODE_W > CNT_W) ? CODE_W : CNT_W) + 1;
  localparam logic [SUM_W-1:0] MIN_S = SUM_W'(MIN_DT);
  localparam logic [SUM_W-1:0] MAX_S = SUM_W'(MAX_DT);

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] clamped;

  always_comb begin
    sum     = MIN_S + SUM_W'(code);
    clamped = (sum > MAX_S) ? MAX_S : sum;
    len_m1  = CNT_W'(clamped - SUM_W'(1));
  end
endmodule

// File: rtl/hbdt_timer.sv
// Shared down-counter for both transition directions.
module hbdt_timer #(
  parameter int MAX_DT = 500,
  parameter int CNT_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done,
  output logic             busy_next
);
  localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(MAX_DT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = load || (cnt_q != '0);
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= RST_VAL;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign done      = (cnt_q == '0);
  assign busy_next = (cnt_d != '0);
endmodule

// File: rtl/hbdt_chan.sv
// One gate channel: turn-on qualification, arming after faults, gate register.
module hbdt_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_own,
  input  logic cmd_other,
  input  logic ok,
  input  logic done,
  input  logic gate_other_q,
  output logic gate_q,
  output logic gate_d,
  output logic drop
);
  logic arm_q;
  logic arm_d;

  always_comb begin
    arm_d  = ok && (arm_q || (done && !cmd_own));
    gate_d = ok && arm_q && cmd_own && !cmd_other &&
             (gate_q || (done && !gate_other_q));
    drop   = gate_q && !gate_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      gate_q <= gate_d;
    end
  end
endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl #(
  parameter int MIN_DT = 40,
  parameter int MAX_DT = 500,
  parameter int CODE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_hi,
  input  logic              cmd_lo,
  input  logic [CODE_W-1:0] dt_code,
  input  logic              cfg_ok,
  input  logic              logic_uv,
  input  logic              float_uv,
  output logic              gate_hi,
  output logic              gate_lo,
  output logic [2:0]        status
);
  import hbdt_pkg::*;

  localparam int CNT_W = $clog2(MAX_DT + 1);
  localparam int NCH   = 2; // index 0 high side, 1 low side

  logic [CNT_W-1:0] len_m1;
  logic             done;
  logic             busy_next;
  logic             ok_lo;
  logic             ok_hi;
  logic             load;
  logic [NCH-1:0]   cmd_v;
  logic [NCH-1:0]   ok_v;
  logic [NCH-1:0]   gate_v;
  logic [NCH-1:0]   gate_dv;
  logic [NCH-1:0]   drop_v;
  hb_state_e        st_q;
  hb_state_e        st_d;

  assign ok_lo = cfg_ok && !logic_uv;
  assign ok_hi = ok_lo && !float_uv;
  assign cmd_v = {cmd_lo, cmd_hi};
  assign ok_v  = {ok_lo, ok_hi};
  assign load  = !ok_lo || (|drop_v);

  hbdt_len #(.MIN_DT(MIN_DT), .MAX_DT(MAX_DT), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_len (
    .code   (dt_code),
    .len_m1 (len_m1)
  );

  hbdt_timer #(.MAX_DT(MAX_DT), .CNT_W(CNT_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_val  (len_m1),
    .done      (done),
    .busy_next (busy_next)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    hbdt_chan u_ch (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_own      (cmd_v[i]),
      .cmd_other    (cmd_v[NCH-1-i]),
      .ok           (ok_v[i]),
      .done         (done),
      .gate_other_q (gate_v[NCH-1-i]),
      .gate_q       (gate_v[i]),
      .gate_d       (gate_dv[i]),
      .drop         (drop_v[i])
    );
  end

  always_comb begin
    if (!cfg_ok)        st_d = ST_PROT;
    else if (logic_uv)  st_d = ST_FAULT;
    else if (gate_dv[0]) st_d = ST_HI;
    else if (gate_dv[1]) st_d = ST_LO;
    else if (float_uv)  st_d = ST_FAULT;
    else if (busy_next) st_d = ST_DEAD;
    else                st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_DEAD;
    else        st_q <= st_d;
  end

  assign gate_hi = gate_v[0];
  assign gate_lo = gate_v[1];
  assign status  = st_q;
endmodule

// File: rtl/hb_deadtime_chk.sv
module hb_deadtime_chk #(
  parameter int MIN_DT = 40,
  parameter int MAX_DT = 500
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_hi,
  input logic       cmd_lo,
  input logic       cfg_ok,
  input logic       logic_uv,
  input logic       float_uv,
  input logic       gate_hi,
  input logic       gate_lo,
  input logic [2:0] status
);
  localparam int OW = $clog2(MAX_DT + 1) + 1;
  localparam logic [OW-1:0] CAP = OW'(MAX_DT);
  localparam logic [OW-1:0] MINV = OW'(MIN_DT);

  logic [OW-1:0] off_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 off_cyc <= '0;
    else if (gate_hi || gate_lo) off_cyc <= '0;
    else if (off_cyc != CAP)     off_cyc <= off_cyc + OW'(1);
  end

  a_r1_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  a_r2_hi_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> off_cyc >= MINV);

  a_r2_lo_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> off_cyc >= MINV);

  a_r4_cross_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hi && cmd_lo) |=> (!gate_hi && !gate_lo));

  a_r5_prot_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok |=> (!gate_hi && !gate_lo && status == 3'd5));

  a_r6_logic_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_uv && cfg_ok) |=> (!gate_hi && !gate_lo && status == 3'd4));

  a_r7_float_fault_hi_off: assert property (@(posedge clk) disable iff (!rst_n)
    float_uv |=> !gate_hi);

  a_r10_status_hi: assert property (@(posedge clk) disable iff (!rst_n)
    gate_hi |-> status == 3'd1);

  a_r10_status_lo: assert property (@(posedge clk) disable iff (!rst_n)
    gate_lo |-> status == 3'd2);
endmodule

bind hb_deadtime_ctrl hb_deadtime_chk #(.MIN_DT(MIN_DT), .MAX_DT(MAX_DT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_hi   (cmd_hi),
  .cmd_lo   (cmd_lo),
  .cfg_ok   (cfg_ok),
  .logic_uv (logic_uv),
  .float_uv (float_uv),
  .gate_hi  (gate_hi),
  .gate_lo  (gate_lo),
  .status   (status)
);

// File: tb/sim_hb_deadtime_ctrl.sv
`timescale 1ns/1ps
module sim_hb_deadtime_ctrl;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_hi, cmd_lo, cfg_ok, logic_uv, float_uv;
  logic [8:0] dt_code;
  logic       gate_hi, gate_lo;
  logic [2:0] status;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #(CLK_NS/2) clk = ~clk;

  hb_deadtime_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .dt_code(dt_code), .cfg_ok(cfg_ok), .logic_uv(logic_uv),
    .float_uv(float_uv), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .status(status)
  );

  function automatic int exp_len(input int code);
    return (40 + code > 500) ? 500 : 40 + code;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_hi();
    cmd_hi = 0; cmd_lo = 0; cyc(520);
    cmd_hi = 1; cyc(2);
  endtask

  // gap in cycles with both gates off until the target gate turns on
  task automatic swap(input bit to_lo, output int gap, output int st_mid);
    gap = 0; st_mid = -1;
    cmd_hi = !to_lo; cmd_lo = to_lo;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (to_lo ? gate_lo : gate_hi) break;
      if (!gate_hi && !gate_lo) gap++;
      if (gap == 10) st_mid = status;
    end
  endtask

  task automatic t_reset();
    chk(gate_hi == 0 && gate_lo == 0, "R9 gates in reset", {gate_hi, gate_lo}, 0);
    chk(status == 3, "R9 status in reset", status, 3);
    @(negedge clk); rst_n = 1; cmd_hi = 1;
    cyc(700);
    chk(gate_hi == 0, "R8 level high after reset ignored", gate_hi, 0);
    cmd_hi = 0; cyc(3); cmd_hi = 1; cyc(2);
    chk(gate_hi == 1, "R8 fresh edge after reset", gate_hi, 1);
    chk(status == 1, "R10 status high on", status, 1);
  endtask

  task automatic t_dead(input int code);
    int g, s;
    dt_code = 9'(code);
    go_hi();
    swap(1, g, s);
    chk(g == exp_len(code), "R2 deadtime high-to-low", g, exp_len(code));
    chk(s == 3, "R10 status during deadtime", s, 3);
    chk(status == 2, "R10 status low on", status, 2);
    swap(0, g, s);
    chk(g == exp_len(code), "R2 deadtime low-to-high", g, exp_len(code));
  endtask

  task automatic t_long_gap();
    dt_code = 9'd20;
    go_hi();
    cmd_hi = 0; cyc(exp_len(20) + 20);
    chk(status == 0, "R10 status idle", status, 0);
    cmd_lo = 1; cyc(1);
    chk(gate_lo == 1, "R3 long gap no extra delay", gate_lo, 1);
  endtask

  task automatic t_sample();
    int g, s;
    dt_code = 9'd0;
    go_hi();
    cmd_hi = 0; cmd_lo = 1; g = 0;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (k == 5) dt_code = 9'd400;
      if (gate_lo) break;
      if (!gate_hi) g++;
    end
    chk(g == 40, "R11 code change during deadtime ignored", g, 40);
    dt_code = 9'd0;
  endtask

  task automatic t_cross();
    go_hi();
    cmd_lo = 1; cyc(1);
    chk(gate_hi == 0 && gate_lo == 0, "R4 both commands high", {gate_hi, gate_lo}, 0);
    cyc(100);
    chk(gate_hi == 0 && gate_lo == 0, "R4 still both off", {gate_hi, gate_lo}, 0);
    chk(!(gate_hi && gate_lo), "R1 not both on", {gate_hi, gate_lo}, 0);
  endtask

  task automatic t_prot();
    go_hi();
    cfg_ok = 0; cyc(1);
    chk(gate_hi == 0 && gate_lo == 0, "R5 protection gates off", {gate_hi, gate_lo}, 0);
    chk(status == 5, "R5 protection status", status, 5);
    cfg_ok = 1; cyc(600);
    chk(gate_hi == 0, "R8 level high after protection ignored", gate_hi, 0);
  endtask

  task automatic t_logic_fault();
    cmd_hi = 0; cmd_lo = 0; cyc(520); cmd_lo = 1; cyc(2);
    chk(gate_lo == 1, "R6 setup low on", gate_lo, 1);
    logic_uv = 1; cyc(1);
    chk(gate_hi == 0 && gate_lo == 0, "R6 logic fault gates off", {gate_hi, gate_lo}, 0);
    chk(status == 4, "R6 logic fault status", status, 4);
    logic_uv = 0; cyc(600);
    chk(gate_lo == 0, "R8 level high after logic fault ignored", gate_lo, 0);
    cmd_lo = 0; cyc(3); cmd_lo = 1; cyc(2);
    chk(gate_lo == 1, "R8 fresh edge after logic fault", gate_lo, 1);
  endtask

  task automatic t_float_fault();
    cmd_hi = 0; cmd_lo = 0; cyc(520); cmd_lo = 1; cyc(2);
    float_uv = 1; cyc(5);
    chk(gate_lo == 1, "R7 low unaffected by floating fault", gate_lo, 1);
    cmd_lo = 0; cyc(520);
    cmd_hi = 1; cyc(5);
    chk(gate_hi == 0, "R7 high held off by floating fault", gate_hi, 0);
    chk(status == 4, "R7 floating fault status", status, 4);
    float_uv = 0; cyc(600);
    chk(gate_hi == 0, "R8 level high after floating fault ignored", gate_hi, 0);
    go_hi();
    chk(gate_hi == 1, "R7 high recovers", gate_hi, 1);
    float_uv = 1; cyc(1);
    chk(gate_hi == 0, "R7 floating fault drops high gate", gate_hi, 0);
    float_uv = 0;
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_hi = 0; cmd_lo = 0; dt_code = 0;
    cfg_ok = 1; logic_uv = 0; float_uv = 0;
    cyc(3);
    t_reset();
    t_dead(0);
    t_dead(100);
    t_dead(470);
    t_long_gap();
    t_sample();
    t_cross();
    t_prot();
    t_logic_fault();
    t_float_fault();
    ended = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule